// File: doc/BRIEF.md
# Sampled Duty-Cycle Pulse Modulator

This block turns a fractional duty-cycle word into a pulse train that advances one sample per clock enable. Each period is a programmable whole number of samples. The pulse starts on the first sample of a period and stays active for the floor of the duty fraction times the period length. The output then rests at the low level until the next period begins. The active and resting output values are two programmable level words, so the output can drive a multi-bit datapath and not only a single gate line.

Before the first period, the pulse train can be pushed back by an initial delay. The delay is given in samples with a fractional part, and that fraction is dropped. An error flag reports two cases: a nonzero delay that is not longer than one sample, and a zero duty while the zero-duty guard is enabled. Both the duty and the period are captured only at a period boundary, so a change that arrives in the middle of a period never produces a runt pulse.

Top module: `duty_pwm_gen`

## Requirements
- R1: The duty input is unsigned, with code 0x8000 meaning 1.0, and any larger code is treated as 1.0. The number of active samples in a period is floor(clampedDuty × periodLen / 32768).
- R2: A period lasts periodLen enabled ticks. Its active samples are the first ones of the period and they are contiguous, and every later sample of that period is at the low level.
- R3: During an active sample the output equals levelHigh, and during every other sample it equals levelLow.
- R4: The delay input has 4 fractional bits (LSB = 1/16 sample). The first period starts at tick index floor(delayRaw/16), counted from 0 at the first enabled tick after reset, and every earlier sample is at the low level.
- R5: errFlag is high one clock after delayRaw is nonzero and at most 16 (one whole sample), and low for delayRaw of 0 or greater than 16 when no guard error is present.
- R6: With guardEn high, a duty code of 0 drives errFlag high one clock later. With guardEn low, a duty of 0 leaves errFlag low and holds the output low for the whole period.
- R7: Duty and periodLen are sampled only on the first tick of a period. A change in mid-period takes effect from the next period.
- R8: A duty of 1.0, or any saturated code, keeps the output high for every sample of the period.
- R9: The output and the counters change only on clocks where tickEn is high.
- R10: A synchronous active-high reset drives the output to levelLow and clears errFlag. Counting restarts with the initial delay at the first enabled tick after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Sample tick enable |
| dutyIn | input | DUTY_W (16) | Duty fraction, 0x8000 = 1.0 |
| periodLen | input | PER_W (12) | Period length in samples |
| delayRaw | input | DLY_W+DLY_FRAC (16) | Initial delay in 1/16 sample units |
| guardEn | input | 1 | Zero-duty guard enable |
| levelHigh | input | LVL_W (8) | Output value during active samples |
| levelLow | input | LVL_W (8) | Output value otherwise |
| pwmOut | output | LVL_W (8) | Modulated output |
| errFlag | output | 1 | Configuration or guard error |

## Verification
The assertions assume that periodLen is at least one sample. The position-range property and the bound on the captured high count rely on this, because a zero period would leave the position counter with no wrap point. The bench never drives a zero period, and it changes the period only from reset or on a boundary where the block captures it. The assertions also assume that levelHigh and levelLow may change at any time, so the level checks compare against the level values from the preceding clock. The bench changes duty in mid-period only in the directed test that exercises R7.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  // Strobes passed from control to datapath for one clock.
  typedef struct packed {
    logic emit;    // an enabled sample tick happens this clock
    logic load;    // this tick is the first sample of a period
    logic active;  // this tick belongs to a period (delay is over)
  } pwmStrobe_t;

endpackage

// File: rtl/dpwm_ctrl.sv
module dpwm_ctrl
  import dpwm_pkg::*;
#(
  parameter int PER_W    = 12,
  parameter int DLY_W    = 12,
  parameter int DLY_FRAC = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tickEn,
  input  logic [PER_W-1:0]          periodLen,
  input  logic [DLY_W+DLY_FRAC-1:0] delayRaw,
  output pwmStrobe_t                strobe,
  output logic [PER_W-1:0]          curPos
);

  logic             running;
  logic [DLY_W-1:0] delayCnt;
  logic [PER_W-1:0] posReg;
  logic [PER_W-1:0] periodReg;

  logic [DLY_W-1:0] delayWhole;
  logic             delayDone;
  logic             atStart;
  logic [PER_W-1:0] wrapLen;
  logic [PER_W:0]   posInc;
  logic [PER_W-1:0] nextPos;

  // Dropping the fraction bits floors the delay to whole samples.
  assign delayWhole = delayRaw[DLY_FRAC +: DLY_W];
  assign delayDone  = (delayCnt == delayWhole);

  always_comb begin
    atStart = running ? (posReg == '0) : delayDone;
    curPos  = running ? posReg : '0;
    wrapLen = atStart ? periodLen : periodReg;
    posInc  = {1'b0, curPos} + 1'b1;
    nextPos = (posInc == {1'b0, wrapLen}) ? '0 : posInc[PER_W-1:0];
    strobe.emit   = tickEn;
    strobe.load   = tickEn && atStart;
    strobe.active = running || delayDone;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      delayCnt  <= '0;
      posReg    <= '0;
      periodReg <= '0;
    end else if (tickEn) begin
      if (strobe.active) begin
        running <= 1'b1;
        posReg  <= nextPos;
        if (atStart) periodReg <= periodLen;
      end else begin
        delayCnt <= delayCnt + 1'b1;
      end
    end
  end

  // R2: inside a period the position never leaves the captured length
  a_r2_pos_range: assert property (@(posedge clk) disable iff (rst)
    running |-> (posReg < periodReg));

  // R9: counters only move on an enabled tick
  a_r9_ctr_hold: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> ($stable(posReg) && $stable(delayCnt) && $stable(running)));

  // R4: the first period opens only once the floored delay has elapsed
  a_r4_delay_exit: assert property (@(posedge clk) disable iff (rst)
    (tickEn && !running && !delayDone) |=> !running);

endmodule

// File: rtl/dpwm_dpath.sv
module dpwm_dpath
  import dpwm_pkg::*;
#(
  parameter int PER_W    = 12,
  parameter int DLY_W    = 12,
  parameter int DLY_FRAC = 4,
  parameter int DUTY_W   = 16,
  parameter int LVL_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  pwmStrobe_t                strobe,
  input  logic [PER_W-1:0]          curPos,
  input  logic [DUTY_W-1:0]         dutyIn,
  input  logic [PER_W-1:0]          periodLen,
  input  logic [DLY_W+DLY_FRAC-1:0] delayRaw,
  input  logic                      guardEn,
  input  logic [LVL_W-1:0]          levelHigh,
  input  logic [LVL_W-1:0]          levelLow,
  output logic [LVL_W-1:0]          pwmOut,
  output logic                      errFlag
);

  localparam int DLYR_W = DLY_W + DLY_FRAC;
  localparam int PROD_W = DUTY_W + PER_W;
  localparam logic [DUTY_W-1:0] DUTY_ONE   = DUTY_W'(1) << (DUTY_W - 1);
  localparam logic [DLYR_W-1:0] ONE_SAMPLE = DLYR_W'(1) << DLY_FRAC;

  logic [DUTY_W-1:0] dutyClamped;
  logic [PROD_W-1:0] product;
  logic [PER_W-1:0]  newHigh;
  logic [PER_W-1:0]  highCntReg;
  logic [PER_W-1:0]  hcNow;
  logic              isHigh;
  logic              delayBad;
  logic              guardTrip;

  always_comb begin
    dutyClamped = (dutyIn > DUTY_ONE) ? DUTY_ONE : dutyIn;
    product     = PROD_W'(dutyClamped) * PROD_W'(periodLen);
    newHigh     = PER_W'(product >> (DUTY_W - 1));
    hcNow       = strobe.load ? newHigh : highCntReg;
    isHigh      = strobe.active && (curPos < hcNow);
    delayBad    = (delayRaw != '0) && (delayRaw <= ONE_SAMPLE);
    guardTrip   = guardEn && (dutyIn == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      highCntReg <= '0;
      pwmOut     <= levelLow;
      errFlag    <= 1'b0;
    end else begin
      errFlag <= delayBad || guardTrip;
      if (strobe.emit) begin
        if (strobe.load) highCntReg <= newHigh;
        pwmOut <= isHigh ? levelHigh : levelLow;
      end
    end
  end

  // R1: the captured high count never exceeds the captured period
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (highCntReg <= $past(periodLen)));

  // R3: after a tick the output is one of the two level words
  a_r3_levels: assert property (@(posedge clk) disable iff (rst)
    strobe.emit |=> ((pwmOut == $past(levelHigh)) || (pwmOut == $past(levelLow))));

  // R4: ticks during the initial delay produce the low level
  a_r4_delay_low: assert property (@(posedge clk) disable iff (rst)
    (strobe.emit && !strobe.active) |=> (pwmOut == $past(levelLow)));

  // R5: a nonzero delay of one sample or less raises the flag
  a_r5_delay_err: assert property (@(posedge clk) disable iff (rst)
    ((delayRaw != '0) && (delayRaw <= ONE_SAMPLE)) |=> errFlag);

  // R6: guarded zero duty raises the flag
  a_r6_guard_err: assert property (@(posedge clk) disable iff (rst)
    (guardEn && (dutyIn == '0)) |=> errFlag);

  // R9: no tick, no output change
  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.emit |=> $stable(pwmOut));

  // R10: reset leaves the low level and a clear flag
  a_r10_reset: assert property (@(posedge clk)
    rst |=> ((pwmOut == $past(levelLow)) && !errFlag));

endmodule

// File: rtl/duty_pwm_gen.sv
module duty_pwm_gen
  import dpwm_pkg::*;
#(
  parameter int PER_W    = 12,
  parameter int DLY_W    = 12,
  parameter int DLY_FRAC = 4,
  parameter int DUTY_W   = 16,
  parameter int LVL_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tickEn,
  input  logic [DUTY_W-1:0]         dutyIn,
  input  logic [PER_W-1:0]          periodLen,
  input  logic [DLY_W+DLY_FRAC-1:0] delayRaw,
  input  logic                      guardEn,
  input  logic [LVL_W-1:0]          levelHigh,
  input  logic [LVL_W-1:0]          levelLow,
  output logic [LVL_W-1:0]          pwmOut,
  output logic                      errFlag
);

  pwmStrobe_t       strobe;
  logic [PER_W-1:0] curPos;

  dpwm_ctrl #(
    .PER_W(PER_W), .DLY_W(DLY_W), .DLY_FRAC(DLY_FRAC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tickEn(tickEn),
    .periodLen(periodLen), .delayRaw(delayRaw),
    .strobe(strobe), .curPos(curPos)
  );

  dpwm_dpath #(
    .PER_W(PER_W), .DLY_W(DLY_W), .DLY_FRAC(DLY_FRAC),
    .DUTY_W(DUTY_W), .LVL_W(LVL_W)
  ) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .curPos(curPos),
    .dutyIn(dutyIn), .periodLen(periodLen), .delayRaw(delayRaw),
    .guardEn(guardEn), .levelHigh(levelHigh), .levelLow(levelLow),
    .pwmOut(pwmOut), .errFlag(errFlag)
  );

endmodule

// File: tb/duty_pwm_gen_tb.sv
`timescale 1ns/1ps
module duty_pwm_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tickEn = 1'b0;
  logic [15:0] dutyIn = 16'h0;
  logic [11:0] periodLen = 12'd4;
  logic [15:0] delayRaw = 16'h0;
  logic        guardEn = 1'b0;
  logic [7:0]  hiLvl = 8'hA5;
  logic [7:0]  loLvl = 8'h3C;
  logic [7:0]  pwmOut;
  logic        errFlag;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  gapMode = 1'b0;
  bit  finished = 1'b0;
  logic [7:0] lastOut;

  always #2.5 clk = ~clk;

  duty_pwm_gen u_dut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .dutyIn(dutyIn),
    .periodLen(periodLen), .delayRaw(delayRaw), .guardEn(guardEn),
    .levelHigh(hiLvl), .levelLow(loLvl), .pwmOut(pwmOut), .errFlag(errFlag)
  );

  // Vectors: period, duty code, delay (1/16 samples), expected high samples.
  localparam int NV = 12;
  localparam int vPer [NV] = '{4, 10, 10, 10, 10, 7, 1, 1, 100, 100, 3, 4};
  localparam int vDuty[NV] = '{15401, 16384, 32768, 65535, 0, 24576,
                               16384, 32768, 327, 328, 21845, 40000};
  localparam int vDly [NV] = '{109, 0, 32, 0, 40, 0, 0, 48, 0, 0, 17, 0};
  localparam int vExp [NV] = '{1, 5, 10, 10, 0, 5, 0, 1, 0, 1, 1, 4};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    tickEn = 1'b1;
    repeat (2) @(negedge clk);
    check(pwmOut == loLvl, "R10 reset output", pwmOut, loLvl);
    check(errFlag == 1'b0, "R10 reset flag", errFlag, 0);
    rst = 1'b0;
    lastOut = loLvl;
  endtask

  // Produces one sample; in gap mode an idle clock precedes it.
  task automatic takeSample(output logic [7:0] v);
    if (gapMode) begin
      tickEn = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(pwmOut == lastOut, "R9 hold without tick", pwmOut, lastOut);
    end
    tickEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    v = pwmOut;
    lastOut = v;
  endtask

  // Runs one period and counts samples that differ from the expected shape.
  task automatic runPeriod(input int per, input int expHi, output int bad, output int hiCnt);
    logic [7:0] v;
    bad = 0;
    hiCnt = 0;
    for (int m = 0; m < per; m++) begin
      takeSample(v);
      if (v == hiLvl) hiCnt++;
      if (v != ((m < expHi) ? hiLvl : loLvl)) bad++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int bad, hiCnt, lowBad;

    // Table walk: R1 R2 R3 R4 R8
    for (int i = 0; i < NV; i++) begin
      periodLen = 12'(vPer[i]);
      dutyIn    = 16'(vDuty[i]);
      delayRaw  = 16'(vDly[i]);
      guardEn   = 1'b0;
      doReset();
      lowBad = 0;
      for (int j = 0; j < vDly[i] / 16; j++) begin
        takeSample(v);
        if (v != loLvl) lowBad++;
      end
      check(lowBad == 0, "R4 low during delay", lowBad, 0);
      runPeriod(vPer[i], vExp[i], bad, hiCnt);
      check(hiCnt == vExp[i], "R1 high count", hiCnt, vExp[i]);
      check(bad == 0, "R2 R3 pulse shape", bad, 0);
      runPeriod(vPer[i], vExp[i], bad, hiCnt);
      check(bad == 0, (vExp[i] == vPer[i]) ? "R8 full duty second period"
                                           : "R2 second period", bad, 0);
    end

    // R7: mid-period duty change waits for the boundary
    periodLen = 12'd10; dutyIn = 16'h4000; delayRaw = 16'd0;
    doReset();
    hiCnt = 0;
    for (int j = 0; j < 10; j++) begin
      takeSample(v);
      if (v == hiLvl) hiCnt++;
      if (j == 2) dutyIn = 16'h6666;
    end
    check(hiCnt == 5, "R7 current period unchanged", hiCnt, 5);
    runPeriod(10, 7, bad, hiCnt);
    check(hiCnt == 7, "R7 next period uses new duty", hiCnt, 7);

    // R9 and R3: gapped ticks with other levels
    hiLvl = 8'hF0; loLvl = 8'h0F;
    periodLen = 12'd4; dutyIn = 16'h4000; delayRaw = 16'd0;
    doReset();
    gapMode = 1'b1;
    runPeriod(4, 2, bad, hiCnt);
    check(bad == 0, "R9 R3 gapped period", bad, 0);
    gapMode = 1'b0;

    // R10: reset in mid-period restarts including delay (2 samples)
    delayRaw = 16'd32;
    doReset();
    for (int j = 0; j < 3; j++) takeSample(v);
    doReset();
    lowBad = 0;
    for (int j = 0; j < 2; j++) begin
      takeSample(v);
      if (v != loLvl) lowBad++;
    end
    check(lowBad == 0, "R10 delay replayed", lowBad, 0);
    takeSample(v);
    check(v == hiLvl, "R10 first period after delay", v, hiLvl);

    // R5: delay error window
    guardEn = 1'b0; dutyIn = 16'h4000;
    delayRaw = 16'd16; repeat (2) @(negedge clk);
    check(errFlag == 1'b1, "R5 delay of one sample", errFlag, 1);
    delayRaw = 16'd8; repeat (2) @(negedge clk);
    check(errFlag == 1'b1, "R5 delay below one sample", errFlag, 1);
    delayRaw = 16'd17; repeat (2) @(negedge clk);
    check(errFlag == 1'b0, "R5 delay above one sample", errFlag, 0);
    delayRaw = 16'd0; repeat (2) @(negedge clk);
    check(errFlag == 1'b0, "R5 zero delay", errFlag, 0);

    // R6: zero-duty guard
    dutyIn = 16'h0; guardEn = 1'b1; repeat (2) @(negedge clk);
    check(errFlag == 1'b1, "R6 guarded zero duty", errFlag, 1);
    guardEn = 1'b0; repeat (2) @(negedge clk);
    check(errFlag == 1'b0, "R6 unguarded zero duty", errFlag, 0);
    dutyIn = 16'h4000; guardEn = 1'b1; repeat (2) @(negedge clk);
    check(errFlag == 1'b0, "R6 guarded nonzero duty", errFlag, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule